// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a 16-pin general-purpose I/O port that sits on a simple single-cycle register bus. Three registers control every pin: a data latch, a direction mask and an open-drain mask. From these registers the block produces a per-pin output value and a per-pin output enable. Pin inputs are resynchronised by a two-flop chain before software can read them. When a peripheral claims a pin, its output reaches the pad only while the pin's data latch holds 1.

A read of the data address is a merged view. Bits currently treated as outputs return the latch. Bits treated as inputs return the synchronised pin level. The direction that steers this read multiplexer lags the direction register by one bus access. It follows the pipelining of the processor that owns the port: the access issued directly after a direction write still sees the previous direction. The bench uses this lag to reproduce the classic hazard in which a read-modify-write, issued too early, copies a floating pin level into a freshly set latch bit.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, every pad_oe bit is 0 and pad_out is 0. The data, direction and open-drain registers all read 0000h.
- R2: A write to address 0 updates the data latch whatever the pin directions are. bus_be[0] enables bits 7:0 and bus_be[1] enables bits 15:8. A lane whose enable is low keeps its value.
- R3: A read of address 0 returns the latch bit for pins seen as outputs and the synchronised pad_in level for pins seen as inputs. A pad_in change becomes visible only to a read accepted at least two clock edges after the change.
- R4: Outside open-drain mode, pad_oe equals the direction register (address 1, a 1 enables the driver) from the cycle after the write. A pin whose direction bit is 0 never has pad_oe high.
- R5: For a pin with its open-drain bit set (address 2), pad_out is 0. The pad is driven (pad_oe = 1) only while the pin's output value is 0 and its direction bit is 1. An output value of 1 releases the pad.
- R6: The read multiplexer of R3 uses the direction held before the most recent bus access. The access directly after a direction write sees the old direction, and every later access sees the new one.
- R7: When alt_sel is 1 for a pin, its output value is alt_out AND the data latch bit. With the latch bit at 0 the pin outputs 0 whatever alt_out is.
- R8: Reads of addresses 1 and 2 return the direction and open-drain registers. Address 3 reads 0000h, and writes to it change no register.
- R9: A read-modify-write of the data address, issued as the access right after a direction change, reads the changed bits from the pins. Writing the result back replaces those latch bits with the pin levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 open-drain, 3 unused |
| bus_be | input | 2 | Byte-lane write enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read access |
| pad_in | input | 16 | Pin levels from the pads |
| pad_out | output | 16 | Output value per pin |
| pad_oe | output | 16 | Output driver enable per pin |
| alt_sel | input | 16 | Per-pin request that a peripheral output drives the pin |
| alt_out | input | 16 | Peripheral output values |

## Verification
A direction write and the read multiplexer act in neighbouring accesses. The direction register changes at the edge of the write, but the read steering changes only at the edge of the next access. The bench issues a direction write and a data read back to back with no idle cycle between them. It compares the merged read with the pin levels under the old direction, and then with the latch under the new one. The same back-to-back pattern, followed by a write-back, shows that a latch bit set before the direction change is lost. The same sequence with one spare access inserted shows the bit kept.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_OD   = 2'd2,
    REG_NONE = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = pin_raw;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WIDTH/8-1:0] bus_be,
  input  logic [WIDTH-1:0]   bus_wdata,
  input  logic [WIDTH-1:0]   pin_sync,
  output logic [WIDTH-1:0]   data_q,
  output logic [WIDTH-1:0]   dir_q,
  output logic [WIDTH-1:0]   od_q,
  output logic [WIDTH-1:0]   rdata_q
);
  localparam int unsigned LANES = WIDTH / 8;

  logic [WIDTH-1:0] data_d, dir_d, od_d, rdata_d;
  logic [WIDTH-1:0] dir_seen_q, dir_seen_d;
  logic [WIDTH-1:0] lane_mask;
  logic             wr_en, rd_en;
  gpio_reg_e        sel_reg;

  assign sel_reg = gpio_reg_e'(bus_addr);
  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;

  always_comb begin
    lane_mask = '0;
    for (int l = 0; l < LANES; l++) begin
      if (bus_be[l]) lane_mask[l*8 +: 8] = 8'hFF;
    end
  end

  // next-state process
  always_comb begin
    data_d     = data_q;
    dir_d      = dir_q;
    od_d       = od_q;
    rdata_d    = rdata_q;
    dir_seen_d = dir_seen_q;
    // steering direction trails the register by one access
    if (bus_sel) dir_seen_d = dir_q;
    if (wr_en) begin
      unique case (sel_reg)
        REG_DATA: data_d = (data_q & ~lane_mask) | (bus_wdata & lane_mask);
        REG_DIR:  dir_d  = (dir_q  & ~lane_mask) | (bus_wdata & lane_mask);
        REG_OD:   od_d   = (od_q   & ~lane_mask) | (bus_wdata & lane_mask);
        REG_NONE: ;
      endcase
    end
    if (rd_en) begin
      unique case (sel_reg)
        REG_DATA: rdata_d = (data_q & dir_seen_q) | (pin_sync & ~dir_seen_q);
        REG_DIR:  rdata_d = dir_q;
        REG_OD:   rdata_d = od_q;
        REG_NONE: rdata_d = '0;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      dir_q      <= '0;
      od_q       <= '0;
      rdata_q    <= '0;
      dir_seen_q <= '0;
    end else begin
      data_q     <= data_d;
      dir_q      <= dir_d;
      od_q       <= od_d;
      rdata_q    <= rdata_d;
      dir_seen_q <= dir_seen_d;
    end
  end
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv (
  input  logic latch_bit,
  input  logic dir_bit,
  input  logic od_bit,
  input  logic periph_sel,
  input  logic periph_val,
  output logic drv_en,
  output logic drv_val
);
  logic out_val;

  // peripheral output is gated by the latch bit
  assign out_val = periph_sel ? (periph_val & latch_bit) : latch_bit;
  // open-drain: pull low only, release on one
  assign drv_val = out_val & ~od_bit;
  assign drv_en  = dir_bit & ~(od_bit & out_val);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WIDTH/8-1:0] bus_be,
  input  logic [WIDTH-1:0]   bus_wdata,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]   pad_in,
  output logic [WIDTH-1:0]   pad_out,
  output logic [WIDTH-1:0]   pad_oe,
  input  logic [WIDTH-1:0]   alt_sel,
  input  logic [WIDTH-1:0]   alt_out
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] data_q, dir_q, od_q;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_raw  (pad_in),
    .pin_sync (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .pin_sync  (pin_sync),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .od_q      (od_q),
    .rdata_q   (bus_rdata)
  );

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    gpio_pin_drv u_drv (
      .latch_bit  (data_q[p]),
      .dir_bit    (dir_q[p]),
      .od_bit     (od_q[p]),
      .periph_sel (alt_sel[p]),
      .periph_val (alt_out[p]),
      .drv_en     (pad_oe[p]),
      .drv_val    (pad_out[p])
    );
  end
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [WIDTH/8-1:0] bus_be,
  input logic [WIDTH-1:0]   bus_wdata,
  input logic [WIDTH-1:0]   data_q,
  input logic [WIDTH-1:0]   dir_q,
  input logic [WIDTH-1:0]   od_q,
  input logic [WIDTH-1:0]   pad_oe,
  input logic [WIDTH-1:0]   pad_out,
  input logic [WIDTH-1:0]   alt_sel
);
  localparam int unsigned LANES = WIDTH / 8;

  logic data_wr;
  assign data_wr = bus_sel && bus_wr && (bus_addr == REG_DATA);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_out == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assert_lane_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && bus_be[l]) |=> data_q[l*8 +: 8] == $past(bus_wdata[l*8 +: 8]));
    assert_lane_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !bus_be[l]) |=> $stable(data_q[l*8 +: 8]));
  end

  assert_dir_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == REG_DIR && (&bus_be) && od_q == '0)
    |=> pad_oe == $past(bus_wdata));

  assert_input_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);

  assert_od_low_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & od_q) == '0);

  assert_alt_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & alt_sel & ~data_q) == '0);
endmodule

bind gpio_port_ctrl gpio_port_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .data_q    (data_q),
  .dir_q     (dir_q),
  .od_q      (od_q),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .alt_sel   (alt_sel)
);

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr, bus_be;
  logic [15:0] bus_wdata, bus_rdata;
  logic [15:0] pad_in, pad_out, pad_oe, alt_sel, alt_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .alt_sel(alt_sel), .alt_out(alt_out)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus access; called at a negedge, returns at the next negedge
  task automatic acc(input logic wr, input logic [1:0] a, input logic [1:0] be,
                     input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    acc(1'b1, a, 2'b11, d);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    acc(1'b0, a, 2'b00, 16'h0);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(2'd2, 16'h0); wr(2'd1, 16'h0); wr(2'd0, 16'h0);
    alt_sel = '0; alt_out = '0;
    idle(3);
    wr(2'd3, 16'h0); // spare access so the steering direction catches up
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 pad_oe in reset", pad_oe, 16'h0000);
    check("R1 pad_out in reset", pad_out, 16'h0000);
    rst_n = 1'b1;
    idle(4);
    check("R1 pad_oe after reset", pad_oe, 16'h0000);
    rd(2'd1, v); check("R1 direction reg", v, 16'h0000);
    rd(2'd2, v); check("R1 open-drain reg", v, 16'h0000);
    wr(2'd1, 16'hFFFF); wr(2'd3, 16'h0);
    rd(2'd0, v); check("R1 data latch", v, 16'h0000);
    clear_all();
  endtask

  task automatic t_data_write();
    logic [15:0] v;
    wr(2'd0, 16'hA55A);               // written while all pins are inputs
    acc(1'b1, 2'd0, 2'b01, 16'h1234); // low lane only
    wr(2'd1, 16'hFFFF); wr(2'd3, 16'h0);
    rd(2'd0, v);
    check("R2 latch written as input, byte lane", v, 16'hA534);
    check("R4 pad_out follows latch", pad_out, 16'hA534);
    check("R4 all drivers on", pad_oe, 16'hFFFF);
    clear_all();
  endtask

  task automatic t_read_mux();
    logic [15:0] v;
    wr(2'd1, 16'h00FF); wr(2'd0, 16'h1234);
    pad_in = 16'hBEEF;
    idle(3);
    rd(2'd0, v); check("R3 merged read", v, 16'hBE34);
    pad_in = 16'h4100;
    rd(2'd0, v); check("R3 sync latency", v, 16'hBE34);
    idle(2);
    rd(2'd0, v); check("R3 new pin level", v, 16'h4134);
    pad_in = 16'h0000;
    clear_all();
  endtask

  task automatic t_direction();
    wr(2'd1, 16'h0F0F);
    check("R4 pad_oe after dir write", pad_oe, 16'h0F0F);
    wr(2'd1, 16'h0000);
    check("R4 pad_oe released", pad_oe, 16'h0000);
    clear_all();
  endtask

  task automatic t_open_drain();
    wr(2'd0, 16'h00F0); wr(2'd1, 16'h00FF); wr(2'd2, 16'h00CC);
    check("R5 open-drain pad_out", pad_out, 16'h0030);
    check("R5 open-drain pad_oe", pad_oe, 16'h003F);
    clear_all();
  endtask

  task automatic t_dir_delay();
    logic [15:0] v;
    pad_in = 16'hFFFF;
    idle(3);
    wr(2'd3, 16'h0);
    wr(2'd1, 16'h0001);
    rd(2'd0, v); check("R6 first access sees input", v, 16'hFFFF);
    rd(2'd0, v); check("R6 second access sees output", v, 16'hFFFE);
    wr(2'd1, 16'h0000);
    rd(2'd0, v); check("R6 first access still output", v, 16'hFFFE);
    rd(2'd0, v); check("R6 back to input", v, 16'hFFFF);
    pad_in = 16'h0000;
    clear_all();
  endtask

  task automatic t_alt();
    alt_sel = 16'h0003; alt_out = 16'h0001;
    wr(2'd0, 16'h0001); wr(2'd1, 16'h0003);
    #1 check("R7 alt passes with latch 1", pad_out, 16'h0001);
    alt_out = 16'h0003;
    #1 check("R7 alt blocked with latch 0", pad_out, 16'h0001);
    alt_out = 16'h0000;
    #1 check("R7 alt low", pad_out, 16'h0000);
    check("R7 drivers on", pad_oe, 16'h0003);
    @(negedge clk);
    clear_all();
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(2'd2, 16'h5A00); wr(2'd1, 16'h0081); wr(2'd0, 16'h0F00);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); check("R8 unused address reads zero", v, 16'h0000);
    rd(2'd2, v); check("R8 open-drain readback", v, 16'h5A00);
    rd(2'd1, v); check("R8 direction readback", v, 16'h0081);
    wr(2'd1, 16'hFFFF); wr(2'd3, 16'h0);
    rd(2'd0, v); check("R8 data untouched by address 3", v, 16'h0F00);
    clear_all();
  endtask

  task automatic t_hazard();
    logic [15:0] v;
    // back-to-back read-modify-write after the direction change
    wr(2'd0, 16'h0020); wr(2'd1, 16'h0020);
    rd(2'd0, v);
    wr(2'd0, v | 16'h0200);
    wr(2'd3, 16'h0);
    rd(2'd0, v);
    check("R9 latch lost to floating pin", v, 16'h0000);
    check("R9 pin driven low", pad_out, 16'h0200);
    clear_all();
    // same sequence with a spare access
    wr(2'd0, 16'h0020); wr(2'd1, 16'h0020);
    rd(2'd2, v);
    rd(2'd0, v);
    wr(2'd0, v | 16'h0200);
    rd(2'd0, v);
    check("R9 spare access keeps latch", v, 16'h0020);
    check("R9 spare access pad_out", pad_out, 16'h0220);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0;
    bus_wdata = '0; pad_in = '0; alt_sel = '0; alt_out = '0;
    idle(3);
    t_reset();
    t_data_write();
    t_read_mux();
    t_direction();
    t_open_drain();
    t_dir_delay();
    t_alt();
    t_regs();
    t_hazard();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule